// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves one frame of data in each direction over a three-wire serial link: a serial clock, a data input and a data output. It can either generate the serial clock itself (master) or follow a clock supplied from outside (slave). Each frame is 8 or 16 bits long. The bits travel either least-significant first or most-significant first. In master mode a 4-bit select field sets the clock period.

Software sets the mode inputs, places a word on `tx_word` and pulses `start`. The mode is captured at that moment. When the last bit has been exchanged, the received word appears on `rx_word` and `done` rises. The serial clock rests high. The data output changes on each falling clock edge, and the data input is taken on each rising edge.

The controller is a four-state machine. The states are `ST_IDLE` (waiting), `ST_LOW` (master, clock low), `ST_HIGH` (master, clock high) and `ST_SLAVE` (following the external clock). Its transitions are:
- IDLE→LOW on an accepted master start, which also presents the first bit.
- IDLE→SLAVE on an accepted slave start.
- LOW→HIGH when the phase timer expires, which samples one bit.
- HIGH→LOW when the phase timer expires and bits remain, which presents the next bit.
- HIGH→IDLE when the phase timer expires after the last bit, which sets `done`.
- SLAVE→IDLE on the external rising edge that carries the last bit, which also sets `done`.

Top module: `sio_port`

## Requirements
- R1: After reset `sck_out`=1, `sck_oe`=0, `sdo`=1, `done`=0 and `rx_word`=0.
- R2: In master mode (`cfg_master`=1) each low and each high phase of `sck_out` lasts `cfg_div_sel`+1 clock cycles. `sck_oe` is 1 while a frame runs, and `sck_out` rests at 1 between frames.
- R3: `sdo` changes only at a falling serial clock edge and is held through the following low and high phases. The input bit is taken at the rising edge.
- R4: `cfg_lsb_first`=1 sends `tx_word` bit 0 first and stores the first received bit as bit 0. `cfg_lsb_first`=0 sends the top bit of the frame first and stores the first received bit as the top bit of the frame.
- R5: `cfg_wide`=1 selects 16-bit frames. `cfg_wide`=0 selects 8-bit frames made of `tx_word[7:0]`, and `tx_word[15:8]` is not sent.
- R6: After an 8-bit frame the received byte sits in `rx_word[7:0]` and `rx_word[15:8]` reads 0.
- R7: `done` goes to 1 after the last bit of a frame. It stays 1 until the next accepted start and is 0 from the cycle after that start.
- R8: In slave mode (`cfg_master`=0) `sck_oe` stays 0 and `sck_in` passes through a two-stage synchroniser. Each `sck_in` phase must last at least 4 clock cycles. One bit is exchanged per external rising edge.
- R9: The mode inputs are captured when a start is accepted. A `start` pulse during a frame has no effect on that frame and does not begin another.
- R10: A master frame produces exactly as many falling `sck_out` edges as the frame has bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = generate the serial clock, 0 = follow `sck_in` |
| cfg_lsb_first | input | 1 | 1 = least-significant bit first |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_div_sel | input | 4 | Master phase length minus one, in clock cycles |
| tx_word | input | 16 | Word to transmit |
| start | input | 1 | One-cycle request to begin a frame |
| rx_word | output | 16 | Last received word, right-aligned |
| done | output | 1 | Frame complete flag |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The assertions take three things for granted. `start` is a single-cycle pulse. In slave mode `sck_in` rests high when the start is given. `sdi` stays steady across the synchroniser delay that follows a rising edge. Under these conditions the captured mode, the bit counter and the held output bit behave as checked.

The bench keeps within these limits. As a slave-side partner it changes `sdi` only as it sees `sck_out` fall. As the clock source in slave mode it holds each `sck_in` phase for six cycles and changes `sdi` only together with the falling edge.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef struct packed {
        logic master;
        logic lsb_first;
        logic wide;
    } sio_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_SLAVE
    } sio_state_e;

endpackage

// File: rtl/sio_clkdiv.sv
module sio_clkdiv #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [SEL_W-1:0] cnt;

    assign tick = run && (cnt == sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2: the phase counter never runs past the selected length
    p_phase_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= sel));

endmodule

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic sdi_raw,
    output logic rise,
    output logic fall,
    output logic sdi_al
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] sdi_p;
    logic              sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p    <= '1;
            sdi_p    <= '0;
            sck_last <= 1'b1;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck_raw};
            sdi_p    <= {sdi_p[STAGES-2:0], sdi_raw};
            sck_last <= sck_p[STAGES-1];
        end
    end

    assign rise   =  sck_p[STAGES-1] & ~sck_last;
    assign fall   = ~sck_p[STAGES-1] &  sck_last;
    assign sdi_al =  sdi_p[STAGES-1];

endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              lsb_first,
    input  logic              wide,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              last,
    input  logic              sdi_bit,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_word
);
    localparam int GAP = DATA_W - SHORT_W;

    logic [DATA_W-1:0] tx_sh, rx_sh, tx_src, rx_next, rx_fin;
    logic              sdo_q;

    always_comb begin
        if (load)
            tx_src = (!lsb_first && !wide) ? (tx_word << GAP) : tx_word;
        else
            tx_src = tx_sh;
        rx_next = lsb_first ? {sdi_bit, rx_sh[DATA_W-1:1]}
                            : {rx_sh[DATA_W-2:0], sdi_bit};
        rx_fin  = (lsb_first && !wide) ? (rx_next >> GAP) : rx_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            sdo_q   <= 1'b1;
            rx_word <= '0;
        end else begin
            if (shift_en) begin
                sdo_q <= lsb_first ? tx_src[0] : tx_src[DATA_W-1];
                tx_sh <= lsb_first ? (tx_src >> 1) : (tx_src << 1);
            end else if (load) begin
                tx_sh <= tx_src;
            end
            if (load)
                rx_sh <= '0;
            else if (sample_en) begin
                rx_sh <= rx_next;
                if (last)
                    rx_word <= rx_fin;
            end
        end
    end

    assign sdo = sdo_q;

    // R3: the data output moves only when a falling edge presents a bit
    p_sdo_only_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sdo_q));

endmodule

// File: rtl/sio_port.sv
module sio_port #(
    parameter int DATA_W      = 16,
    parameter int SHORT_W     = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_lsb_first,
    input  logic              cfg_wide,
    input  logic [SEL_W-1:0]  cfg_div_sel,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              start,
    output logic [DATA_W-1:0] rx_word,
    output logic              done,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo
);
    import sio_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);

    sio_state_e       state, state_nxt;
    sio_mode_t        mode_q, mode_nxt;
    logic [SEL_W-1:0] div_q;
    logic [CNT_W-1:0] bit_cnt, nbits;
    logic             load, shift_en, sample_en, last, finish;
    logic             tick, run, edge_rise, edge_fall, sdi_al, sdi_bit;
    logic             done_q, sck_q, oe_q;

    assign run      = (state == ST_LOW) || (state == ST_HIGH);
    assign nbits    = mode_q.wide ? CNT_W'(DATA_W) : CNT_W'(SHORT_W);
    assign mode_nxt = load ? '{master: cfg_master, lsb_first: cfg_lsb_first, wide: cfg_wide}
                           : mode_q;
    assign sdi_bit  = mode_q.master ? sdi : sdi_al;

    sio_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(div_q), .tick(tick)
    );

    sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_raw(sck_in), .sdi_raw(sdi),
        .rise(edge_rise), .fall(edge_fall), .sdi_al(sdi_al)
    );

    sio_shift #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load),
        .lsb_first(mode_nxt.lsb_first), .wide(mode_nxt.wide),
        .tx_word(tx_word), .shift_en(shift_en), .sample_en(sample_en),
        .last(last), .sdi_bit(sdi_bit), .sdo(sdo), .rx_word(rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // next state and strobes
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        shift_en  = 1'b0;
        sample_en = 1'b0;
        last      = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (cfg_master) begin
                        state_nxt = ST_LOW;
                        shift_en  = 1'b1;
                    end else begin
                        state_nxt = ST_SLAVE;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    state_nxt = ST_HIGH;
                    sample_en = 1'b1;
                    last      = (bit_cnt == nbits - 1'b1);
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (bit_cnt == nbits) begin
                        state_nxt = ST_IDLE;
                        finish    = 1'b1;
                    end else begin
                        state_nxt = ST_LOW;
                        shift_en  = 1'b1;
                    end
                end
            end
            ST_SLAVE: begin
                if (edge_fall)
                    shift_en = 1'b1;
                if (edge_rise) begin
                    sample_en = 1'b1;
                    if (bit_cnt == nbits - 1'b1) begin
                        last      = 1'b1;
                        finish    = 1'b1;
                        state_nxt = ST_IDLE;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            div_q   <= '0;
            bit_cnt <= '0;
            done_q  <= 1'b0;
            sck_q   <= 1'b1;
            oe_q    <= 1'b0;
        end else begin
            mode_q <= mode_nxt;
            if (load) begin
                div_q   <= cfg_div_sel;
                bit_cnt <= '0;
                done_q  <= 1'b0;
            end else begin
                if (sample_en)
                    bit_cnt <= bit_cnt + 1'b1;
                if (finish)
                    done_q <= 1'b1;
            end
            sck_q <= (state_nxt != ST_LOW);
            oe_q  <= (state_nxt == ST_LOW) || (state_nxt == ST_HIGH);
        end
    end

    assign done    = done_q;
    assign sck_out = sck_q;
    assign sck_oe  = oe_q;

    // R7: done only rises at the end of a running frame
    p_done_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) != ST_IDLE));

    // R7: an accepted start clears done on the next cycle
    p_start_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE) |=> !done);

    // R9: captured mode and divider hold while a frame runs
    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(mode_q) && $stable(div_q)));

    // R8: the clock is never driven while following an external clock
    p_slave_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLAVE) |-> !sck_oe);

    // R5: the bit counter never passes the frame length
    p_bits_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= nbits);

endmodule

// File: tb/test_sio_port.sv
module test_sio_port;

    typedef struct packed {
        logic        m;
        logic        l;
        logic        w;
        logic [3:0]  s;
        logic [15:0] tx;
        logic [15:0] rp;
    } vec_t;

    localparam int NVEC = 7;
    localparam int SLV_HALF = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 4'd0,  16'h77A5, 16'h003C},
        '{1'b1, 1'b1, 1'b0, 4'd3,  16'h001E, 16'h00C4},
        '{1'b1, 1'b0, 1'b1, 4'd1,  16'hBEEF, 16'h1234},
        '{1'b1, 1'b1, 1'b1, 4'd15, 16'h8001, 16'h7E5A},
        '{1'b0, 1'b0, 1'b0, 4'd0,  16'hFF96, 16'h005F},
        '{1'b0, 1'b1, 1'b1, 4'd0,  16'hC3A5, 16'h0F0F},
        '{1'b0, 1'b1, 1'b0, 4'd0,  16'h00B1, 16'h0092}
    };

    logic        clk = 1'b0;
    logic        rst_n, cfg_master, cfg_lsb_first, cfg_wide, start, sck_in, sdi;
    logic [3:0]  cfg_div_sel;
    logic [15:0] tx_word, rx_word;
    logic        done, sck_out, sck_oe, sdo;

    int tests = 0;
    int fails = 0;
    int fall_cnt = 0;

    always #2.5 clk = ~clk;

    always @(negedge sck_out) fall_cnt++;

    sio_port i_sio_port (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
        .cfg_wide(cfg_wide), .cfg_div_sel(cfg_div_sel), .tx_word(tx_word), .start(start),
        .rx_word(rx_word), .done(done), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic reply_bit(input vec_t v, input int i);
        int n = v.w ? 16 : 8;
        return v.l ? v.rp[i] : v.rp[n-1-i];
    endfunction

    function automatic int bit_pos(input vec_t v, input int i);
        int n = v.w ? 16 : 8;
        return v.l ? i : n-1-i;
    endfunction

    task automatic pulse_start(input vec_t v);
        cfg_master = v.m; cfg_lsb_first = v.l; cfg_wide = v.w;
        cfg_div_sel = v.s; tx_word = v.tx;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_checks(input vec_t v, input logic [15:0] cap);
        logic [15:0] exp_tx = v.w ? v.tx : {8'h00, v.tx[7:0]};
        logic [15:0] exp_rx = v.w ? v.rp : {8'h00, v.rp[7:0]};
        check(v.w ? "R4 R5 sent frame (16-bit)" : "R4 R5 sent frame (8-bit, upper byte unused)",
              32'(cap), 32'(exp_tx));
        check(v.w ? "R4 received word" : "R6 received byte right-aligned",
              32'(rx_word), 32'(exp_rx));
        check("R7 done after last bit", 32'(done), 32'd1);
    endtask

    task automatic run_master(input vec_t v, input bit poke);
        int n = v.w ? 16 : 8;
        int h = int'(v.s) + 1;
        int bad_phase = 0;
        int bad_hold = 0;
        int base = fall_cnt;
        logic [15:0] cap = '0;
        logic held;
        pulse_start(v);
        for (int i = 0; i < n; i++) begin
            int lo = 0;
            int hi = 0;
            int t = 0;
            while (sck_out !== 1'b0 && t < 100) begin @(negedge clk); t++; end
            if (i == 0) begin
                check("R7 done cleared after start", 32'(done), 32'd0);
                check("R2 sck_oe while master frame runs", 32'(sck_oe), 32'd1);
            end
            sdi  = reply_bit(v, i);
            held = sdo;
            while (sck_out === 1'b0 && lo < 100) begin
                if (poke && i == 1 && lo == 0) begin
                    start = 1'b1; cfg_wide = ~v.w; cfg_lsb_first = ~v.l;
                end else begin
                    start = 1'b0;
                end
                if (sdo !== held) bad_hold++;
                lo++;
                @(negedge clk);
            end
            start = 1'b0;
            if (lo != h) bad_phase++;
            cap[bit_pos(v, i)] = sdo;
            if (i < n-1) begin
                while (sck_out === 1'b1 && hi < 100) begin
                    if (sdo !== held) bad_hold++;
                    hi++;
                    @(negedge clk);
                end
            end else begin
                while (done !== 1'b1 && hi < 100) begin
                    if (sdo !== held) bad_hold++;
                    hi++;
                    @(negedge clk);
                end
            end
            if (hi != h) bad_phase++;
        end
        check("R2 phase lengths equal div_sel+1", 32'(bad_phase), 32'd0);
        check("R3 sdo held between falling edges", 32'(bad_hold), 32'd0);
        finish_checks(v, cap);
        repeat (20) @(negedge clk);
        check("R7 done held until next start", 32'(done), 32'd1);
        check(poke ? "R9 busy start ignored, clock idles high" : "R2 clock idles high",
              32'(sck_out), 32'd1);
        check("R10 falling edges per frame", 32'(fall_cnt - base), 32'(n));
    endtask

    task automatic run_slave(input vec_t v);
        int n = v.w ? 16 : 8;
        int oe_seen = 0;
        int bad_hold = 0;
        logic [15:0] cap = '0;
        pulse_start(v);
        for (int i = 0; i < n; i++) begin
            logic held;
            sck_in = 1'b0;
            sdi    = reply_bit(v, i);
            for (int k = 0; k < SLV_HALF; k++) begin
                @(negedge clk);
                if (sck_oe !== 1'b0) oe_seen++;
            end
            if (i == 0) check("R7 done cleared after slave start", 32'(done), 32'd0);
            held = sdo;
            cap[bit_pos(v, i)] = sdo;
            sck_in = 1'b1;
            for (int k = 0; k < SLV_HALF; k++) begin
                @(negedge clk);
                if (sck_oe !== 1'b0) oe_seen++;
                if (k < 3 && sdo !== held) bad_hold++;
            end
        end
        check("R8 sck_oe stays low in slave mode", 32'(oe_seen), 32'd0);
        check("R3 sdo held after rising edge (slave)", 32'(bad_hold), 32'd0);
        finish_checks(v, cap);
    endtask

    initial begin
        rst_n = 1'b0; cfg_master = 1'b0; cfg_lsb_first = 1'b0; cfg_wide = 1'b0;
        cfg_div_sel = '0; tx_word = '0; start = 1'b0; sck_in = 1'b1; sdi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset sck_out", 32'(sck_out), 32'd1);
        check("R1 reset sck_oe", 32'(sck_oe), 32'd0);
        check("R1 reset sdo", 32'(sdo), 32'd1);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset rx_word", 32'(rx_word), 32'd0);

        for (int j = 0; j < NVEC; j++) begin
            if (VECS[j].m) run_master(VECS[j], 1'b0);
            else           run_slave(VECS[j]);
            repeat (4) @(negedge clk);
        end

        // R9: start pulse and mode change during a running master frame
        run_master('{1'b1, 1'b0, 1'b0, 4'd2, 16'h005A, 16'h00A3}, 1'b1);

        // R8: slave frame right after a master frame, then a master frame again
        run_slave('{1'b0, 1'b0, 1'b1, 4'd0, 16'h1E2D, 16'hA55A});
        run_master('{1'b1, 1'b0, 1'b1, 4'd0, 16'h0001, 16'h8000}, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule